// File: doc/BRIEF.md
# Write Allocate Policy Decision Unit

This block decides, for every pending write that missed the L1 data cache, whether the cache should fetch and allocate a line for it. The decision rests on a software-programmed 64-bit control register that carries an allocation ceiling, counted in 4-Mbyte units, and a separate enable for the 15-to-16-Mbyte address window.

Two further inputs can force allocation whatever the address: a hint that the write targets a cacheable page and a hint that it targets a tracked sector. A third input marks addresses where allocation is forbidden, and it overrides everything else. Software writes the register once it knows how much memory is fitted. For example, 32 Mbytes of memory gives a field value of 8. Each request receives a registered decision one cycle later, together with a valid pulse.

Top module: `wa_policy_unit`

## Requirements
- R1: Reset (synchronous, active low) clears the whole 64-bit control register, so `cfg_rd_data` reads zero, and no decision is valid.
- R2: A write stores only bits 31:22 (the limit field) and bit 16 (the 15–16 Mbyte window enable). Every other bit reads zero whatever was written to it.
- R3: A missing write whose address bits 31:22 are strictly less than the limit field allocates.
- R4: A missing write whose address bits 31:22 are equal to or greater than the limit field does not allocate unless a hint is set.
- R5: With the limit field at zero, no address allocates through the limit.
- R6: A missing write with `req_page_hint` or `req_sector_hint` set allocates at any address, including when the field is zero.
- R7: With bit 16 clear, addresses 0x00F0_0000 to 0x00FF_FFFF do not allocate through the limit, although hints still allocate them. With bit 16 set, these addresses follow the limit.
- R8: `req_no_alloc` forces the decision to no-allocate.
- R9: A write that hits (`req_miss` low) never allocates.
- R10: `dec_valid` pulses in the cycle after each request and only then. `dec_allocate` is low when `dec_valid` is low.
- R11: A request that arrives in the same cycle as a register write is judged with the register contents held before that write.
- R12: With the field at 8, address 0x01FF_FFFF allocates and 0x0200_0000 does not.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr_en | input | 1 | Write strobe for the control register |
| cfg_wr_data | input | 64 | Data to write into the control register |
| cfg_rd_data | output | 64 | Current control register contents |
| req_valid | input | 1 | A pending write is presented |
| req_addr | input | 32 | Physical address of the write |
| req_miss | input | 1 | The write missed the L1 data cache |
| req_page_hint | input | 1 | The write targets a cacheable page |
| req_sector_hint | input | 1 | The write targets a tracked sector |
| req_no_alloc | input | 1 | The address lies in a range where allocation is disallowed |
| dec_valid | output | 1 | The decision is valid (one cycle after the request) |
| dec_allocate | output | 1 | The cache should allocate a line |

## Verification
A register write and a request can land in the same clock cycle, so the request could be judged against either the old or the new limit. The random phase lets writes and requests coincide freely, and a directed case raises the field from 0 to 8 in the same cycle as a request to 16 Mbytes. The bench model updates its register copy only after it has computed that request's expected decision, so any decision based on the new field is reported as a failure.

// File: rtl/wa_pkg.sv
// Shared constants and types for the write-allocate policy unit.
// Assumes a 32-bit physical address and a 64-bit control register.
package wa_pkg;
    localparam int REG_W       = 64;
    localparam int ADDR_W      = 32;
    localparam int LIMIT_LSB   = 22;   // one limit unit = 4 Mbytes
    localparam int LIMIT_W     = 10;
    localparam int WIN_EN_BIT  = 16;
    localparam int WIN_MB      = 15;   // window base, in Mbytes

    // Per-request qualifier flags
    typedef struct packed {
        logic miss;
        logic page_hint;
        logic sector_hint;
        logic no_alloc;
    } wa_flags_t;
endpackage

// File: rtl/wa_ctrl_reg.sv
// Write-handling control register: keeps only the limit field and the
// window enable; all other bits stay zero. Assumes single-cycle writes.
module wa_ctrl_reg #(
    parameter int REG_W      = wa_pkg::REG_W,
    parameter int LIMIT_LSB  = wa_pkg::LIMIT_LSB,
    parameter int LIMIT_W    = wa_pkg::LIMIT_W,
    parameter int WIN_EN_BIT = wa_pkg::WIN_EN_BIT
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [REG_W-1:0]   wr_data,
    output logic [REG_W-1:0]   rd_data,
    output logic [LIMIT_W-1:0] limit_field,
    output logic               win_en
);
    localparam logic [REG_W-1:0] FIELD_MASK =
        {{(REG_W-LIMIT_W){1'b0}}, {LIMIT_W{1'b1}}} << LIMIT_LSB;
    localparam logic [REG_W-1:0] EN_MASK =
        {{(REG_W-1){1'b0}}, 1'b1} << WIN_EN_BIT;
    localparam logic [REG_W-1:0] KEEP_MASK = FIELD_MASK | EN_MASK;

    logic [REG_W-1:0] reg_q;

    // Register storage: reset to zero, writes keep only implemented bits
    always_ff @(posedge clk) begin
        if (!rst_n)
            reg_q <= '0;
        else if (wr_en)
            reg_q <= wr_data & KEEP_MASK;
    end

    // Field extraction for the decision logic
    always_comb begin
        rd_data     = reg_q;
        limit_field = reg_q[LIMIT_LSB +: LIMIT_W];
        win_en      = reg_q[WIN_EN_BIT];
    end

    // A write appears on the read port, masked, in the next cycle
    assert_write_masked_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (rd_data == ($past(wr_data) & KEEP_MASK)));
    // Without a write the register holds its value
    assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(rd_data));
endmodule

// File: rtl/wa_limit_cmp.sv
// Limit comparator: reports that an address is below the programmed
// limit and is not excluded by a disabled 15-16 Mbyte window.
// Assumes the window is exactly 1 Mbyte and lies within the address space.
module wa_limit_cmp #(
    parameter int ADDR_W    = wa_pkg::ADDR_W,
    parameter int LIMIT_LSB = wa_pkg::LIMIT_LSB,
    parameter int LIMIT_W   = wa_pkg::LIMIT_W,
    parameter int WIN_MB    = wa_pkg::WIN_MB,
    parameter bit HAS_WIN   = 1'b1
) (
    input  logic [ADDR_W-1:0]  addr,
    input  logic [LIMIT_W-1:0] limit_field,
    input  logic               win_en,
    output logic               limit_ok
);
    localparam int UPPER_W  = ADDR_W - LIMIT_LSB;
    localparam int CMP_W    = (UPPER_W > LIMIT_W) ? UPPER_W : LIMIT_W;
    localparam int MB_SHIFT = 20;
    localparam int MB_W     = ADDR_W - MB_SHIFT;

    logic [CMP_W-1:0] addr_units;
    logic [CMP_W-1:0] lim_units;
    logic             below;
    logic             win_block;

    // Unit compare: address in 4-Mbyte units strictly below the field
    always_comb begin
        addr_units = CMP_W'(addr[ADDR_W-1:LIMIT_LSB]);
        lim_units  = CMP_W'(limit_field);
        below      = addr_units < lim_units;
    end

    generate
        if (HAS_WIN) begin : g_win
            // Window exclusion: in the window while its enable is clear
            always_comb
                win_block = (addr[ADDR_W-1:MB_SHIFT] == MB_W'(WIN_MB)) && !win_en;
        end else begin : g_nowin
            // No window variant: nothing is excluded
            always_comb win_block = 1'b0;
        end
    endgenerate

    // Combined limit verdict
    always_comb limit_ok = below && !win_block;
endmodule

// File: rtl/wa_policy_unit.sv
// Write-allocate policy decision unit. Combines the limit verdict with
// page and sector hints, applies the disallow override and the hit
// filter, and registers the decision one cycle after the request.
// Assumes at most one request per cycle; requests see the register
// value held before any write in the same cycle.
module wa_policy_unit #(
    parameter int REG_W      = wa_pkg::REG_W,
    parameter int ADDR_W     = wa_pkg::ADDR_W,
    parameter int LIMIT_LSB  = wa_pkg::LIMIT_LSB,
    parameter int LIMIT_W    = wa_pkg::LIMIT_W,
    parameter int WIN_EN_BIT = wa_pkg::WIN_EN_BIT,
    parameter int WIN_MB     = wa_pkg::WIN_MB
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr_en,
    input  logic [REG_W-1:0]  cfg_wr_data,
    output logic [REG_W-1:0]  cfg_rd_data,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_miss,
    input  logic              req_page_hint,
    input  logic              req_sector_hint,
    input  logic              req_no_alloc,
    output logic              dec_valid,
    output logic              dec_allocate
);
    import wa_pkg::*;

    logic [LIMIT_W-1:0] limit_field;
    logic               win_en;
    logic               limit_ok;
    wa_flags_t          flags;
    logic               alloc_d;

    wa_ctrl_reg #(
        .REG_W(REG_W), .LIMIT_LSB(LIMIT_LSB),
        .LIMIT_W(LIMIT_W), .WIN_EN_BIT(WIN_EN_BIT)
    ) i_reg (
        .clk(clk), .rst_n(rst_n),
        .wr_en(cfg_wr_en), .wr_data(cfg_wr_data),
        .rd_data(cfg_rd_data),
        .limit_field(limit_field), .win_en(win_en)
    );

    wa_limit_cmp #(
        .ADDR_W(ADDR_W), .LIMIT_LSB(LIMIT_LSB),
        .LIMIT_W(LIMIT_W), .WIN_MB(WIN_MB), .HAS_WIN(1'b1)
    ) i_cmp (
        .addr(req_addr), .limit_field(limit_field),
        .win_en(win_en), .limit_ok(limit_ok)
    );

    // Source merge: the override and the hit filter dominate all sources
    always_comb begin
        flags   = '{miss: req_miss, page_hint: req_page_hint,
                    sector_hint: req_sector_hint, no_alloc: req_no_alloc};
        alloc_d = flags.miss && !flags.no_alloc &&
                  (limit_ok || flags.page_hint || flags.sector_hint);
    end

    // Decision stage: one-cycle registered verdict with a valid pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dec_valid    <= 1'b0;
            dec_allocate <= 1'b0;
        end else begin
            dec_valid    <= req_valid;
            dec_allocate <= req_valid && alloc_d;
        end
    end

    assert_valid_follows_R10: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> dec_valid);
    assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (!dec_valid && !dec_allocate));
    assert_hit_no_alloc_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_miss) |=> !dec_allocate);
    assert_override_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_no_alloc) |=> !dec_allocate);
    assert_hint_alloc_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_miss && !req_no_alloc && (req_page_hint || req_sector_hint))
        |=> dec_allocate);
    assert_zero_limit_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && cfg_rd_data[LIMIT_LSB +: LIMIT_W] == '0 &&
         !req_page_hint && !req_sector_hint) |=> !dec_allocate);
endmodule

// File: tb/test_wa_policy_unit.sv
module test_wa_policy_unit;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        cfg_wr_en;
    logic [63:0] cfg_wr_data;
    logic [63:0] cfg_rd_data;
    logic        req_valid;
    logic [31:0] req_addr;
    logic        req_miss, req_page_hint, req_sector_hint, req_no_alloc;
    logic        dec_valid, dec_allocate;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;
    logic [63:0] model = '0;
    localparam logic [63:0] KEEP = 64'h0000_0000_FFC1_0000;

    always #2 clk = ~clk;   // 250 MHz

    wa_policy_unit i_wa_policy_unit (
        .clk(clk), .rst_n(rst_n),
        .cfg_wr_en(cfg_wr_en), .cfg_wr_data(cfg_wr_data), .cfg_rd_data(cfg_rd_data),
        .req_valid(req_valid), .req_addr(req_addr), .req_miss(req_miss),
        .req_page_hint(req_page_hint), .req_sector_hint(req_sector_hint),
        .req_no_alloc(req_no_alloc),
        .dec_valid(dec_valid), .dec_allocate(dec_allocate)
    );

    function automatic bit exp_alloc(logic [63:0] r, logic [31:0] a,
                                     bit miss, bit pg, bit sc, bit blk);
        bit below = a[31:22] < r[31:22];
        bit inwin = (a[31:20] == 12'h00F);
        bit lim   = below && !(inwin && !r[16]);
        return miss && !blk && (lim || pg || sc);
    endfunction

    task automatic chk(logic [63:0] got, logic [63:0] exp, string tag);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, got, exp);
        end
    endtask

    task automatic cfg_write(logic [63:0] d, string tag);
        @(negedge clk);
        cfg_wr_en = 1'b1; cfg_wr_data = d;
        @(negedge clk);
        cfg_wr_en = 1'b0;
        model = d & KEEP;
        chk(cfg_rd_data, model, tag);
    endtask

    // Request, optionally with a simultaneous register write (R11)
    task automatic do_req(logic [31:0] a, bit miss, bit pg, bit sc, bit blk,
                          bit wr, logic [63:0] wd, string tag);
        bit e;
        @(negedge clk);
        req_valid = 1'b1; req_addr = a; req_miss = miss;
        req_page_hint = pg; req_sector_hint = sc; req_no_alloc = blk;
        cfg_wr_en = wr; cfg_wr_data = wd;
        e = exp_alloc(model, a, miss, pg, sc, blk);
        if (wr) model = wd & KEEP;
        @(negedge clk);
        req_valid = 1'b0; cfg_wr_en = 1'b0;
        chk({63'b0, dec_valid}, 64'd1, {tag, " R10 valid"});
        chk({63'b0, dec_allocate}, {63'b0, e}, tag);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        rst_n = 1'b0; cfg_wr_en = 1'b0; cfg_wr_data = '0; req_valid = 1'b0;
        req_addr = '0; req_miss = 1'b0; req_page_hint = 1'b0;
        req_sector_hint = 1'b0; req_no_alloc = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(cfg_rd_data, 64'd0, "R1 reset register");
        chk({63'b0, dec_valid}, 64'd0, "R1 reset valid");

        // R2: reserved bits dropped
        cfg_write(64'hFFFF_FFFF_FFFF_FFFF, "R2 all ones");
        cfg_write(64'hFFFF_FFFF_003E_FFFF, "R2 reserved only");
        // R5: field zero, no hints
        cfg_write(64'h0, "R5 clear");
        do_req(32'h0000_1000, 1, 0, 0, 0, 0, '0, "R5 zero limit low addr");
        // R6: hints at field zero and high address
        do_req(32'hFFFF_0000, 1, 1, 0, 0, 0, '0, "R6 page hint");
        do_req(32'h0000_0040, 1, 0, 1, 0, 0, '0, "R6 sector hint");
        // R11: write raises field to 8 in the request's cycle
        do_req(32'h0100_0000, 1, 0, 0, 0, 1, 64'h0000_0000_0200_0000, "R11 old limit used");
        do_req(32'h0100_0000, 1, 0, 0, 0, 0, '0, "R11 new limit next");
        // R12 / R3 / R4: field 8 = 32 Mbytes
        do_req(32'h01FF_FFFF, 1, 0, 0, 0, 0, '0, "R12 R3 just below");
        do_req(32'h0200_0000, 1, 0, 0, 0, 0, '0, "R12 R4 at limit");
        do_req(32'h0300_0000, 1, 0, 0, 0, 0, '0, "R4 above limit");
        // R7: window disabled then enabled
        do_req(32'h00F0_0000, 1, 0, 0, 0, 0, '0, "R7 window blocked");
        do_req(32'h00FF_FFFF, 1, 0, 1, 0, 0, '0, "R7 window hint");
        do_req(32'h00EF_FFFF, 1, 0, 0, 0, 0, '0, "R7 below window");
        cfg_write(64'h0000_0000_0201_0000, "R2 enable window");
        do_req(32'h00F8_0000, 1, 0, 0, 0, 0, '0, "R7 window enabled");
        // R8 / R9
        do_req(32'h0000_0100, 1, 1, 1, 1, 0, '0, "R8 override");
        do_req(32'h0000_0100, 0, 1, 1, 0, 0, '0, "R9 hit");
        // R3: maximum field
        cfg_write(64'h0000_0000_FFC0_0000, "R2 max field");
        do_req(32'hFFBF_FFFF, 1, 0, 0, 0, 0, '0, "R3 max field below");
        do_req(32'hFFC0_0000, 1, 0, 0, 0, 0, '0, "R4 max field at");
        // R10: idle cycle
        @(negedge clk);
        chk({62'b0, dec_valid, dec_allocate}, 64'd0, "R10 idle");

        // Random phase
        for (int i = 0; i < 400; i++) begin
            bit wr = ($urandom % 6) == 0;
            logic [63:0] wd = {$urandom, $urandom};
            logic [31:0] a;
            if ($urandom % 2) wd[31:22] = 10'($urandom % 16);
            case ($urandom % 3)
                0: a = $urandom;
                1: a = {6'($urandom % 64), 26'($urandom)} ;
                default: a = {model[31:22], 22'd0} + 32'($urandom % 3) - 32'd1;
            endcase
            do_req(a, ($urandom % 4) != 0, ($urandom % 5) == 0, ($urandom % 5) == 0,
                   ($urandom % 7) == 0, wr, wd, "R3 R4 R6 R7 R8 R9 R11 random");
            chk(cfg_rd_data, model, "R2 random readback");
        end

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule